// File: doc/BRIEF.md
# Paged Effective Address Generator

This unit turns the address part of a load, store or jump instruction into a 26-bit physical word address. It accepts the 20-bit address field of the instruction, the number and low 20 bits of the index register the instruction names, a 3-bit addressing mode and the 6-bit page number held in bits 21..16 of the status word. It forms a 20-bit logical address by direct use, indexing, indirection or indexing followed by indirection. It then places the page number above that address to relocate it. Memory is addressed in 32-bit words throughout.

Direct and indexed requests finish in one cycle. For the two indirect modes the unit reads one pointer word from memory over a level request / single-cycle valid handshake. The pointer read itself goes to the relocated address. Only the low 20 bits of the returned word are taken as the new logical address. A register-indirect access is obtained from the indexed-indirect mode with an address field of zero.

Top module: `eau_addr_gen`

## Requirements
- R1: Mode code 0 (direct) yields physAddr = {pageNum, addrField} with addrValid high for exactly the cycle after the start cycle and no memory request.
- R2: Mode code 2 (indexed) yields the logical address addrField + idxLow, wrapped modulo 2^20, relocated as in R1 and timed as in R1.
- R3: When idxNum is 0 the index contribution is zero whatever idxLow holds, in both indexed (2) and indexed-indirect (3) modes.
- R4: Mode code 1 (indirect) raises memReq with memAddr = {pageNum, addrField}. When memValid returns, physAddr = {pageNum, memPtr}.
- R5: Mode code 3 (indexed-indirect) indexes first: the pointer is fetched from {pageNum, (addrField + idxLow) mod 2^20}.
- R6: Mode 3 with addrField 0 fetches the pointer from {pageNum, idxLow}, i.e. register-indirect.
- R7: The page bits of both the pointer fetch and the final address are the pageNum sampled in the start cycle.
- R8: In an indirect request, busy and memReq stay high from the cycle after start until the cycle in which memValid is seen, memAddr stays constant meanwhile, and addrValid is high for the single cycle after that.
- R9: Mode codes 4 to 7 behave as direct: no indexing, no memory request.
- R10: A start pulse while busy is high is ignored; the pending request completes with its own result and produces one addrValid.
- R11: After reset busy, memReq and addrValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an address computation with the inputs of this cycle |
| mode | input | 3 | Addressing mode: 0 direct, 1 indirect, 2 indexed, 3 indexed-indirect, others direct |
| addrField | input | 20 | Address field of the instruction |
| idxNum | input | 3 | Number of the index register named by the instruction |
| idxLow | input | 20 | Low 20 bits of that index register |
| pageNum | input | 6 | Page number, status word bits 21..16 |
| busy | output | 1 | Pointer fetch in progress |
| addrValid | output | 1 | One-cycle strobe: physAddr holds a new result |
| physAddr | output | 26 | Physical word address |
| memReq | output | 1 | Pointer read request, held until memValid |
| memAddr | output | 26 | Physical address of the pointer word |
| memValid | input | 1 | Pointer word is on memPtr this cycle |
| memPtr | input | 20 | Low 20 bits of the returned pointer word |

## Verification
A vector table exercises every mode code with addresses chosen to separate the cases. An index that wraps past 2^20 tells modulo addition apart from a widened sum. A nonzero idxLow paired with index number 0 shows whether register zero is really forced to zero. Non-zero and zero address fields in mode 3 separate indexed-indirect from register-indirect. Unused mode codes fed a live index show whether indexing leaks into them. The behavioural memory returns a position-dependent word, so a wrong pointer address or a post-indexed order produces a visibly wrong result. Page 0, page 63 and intermediate pages confirm the relocation bits.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int LOG_W   = 20;
  localparam int PAGE_W  = 6;
  localparam int SEL_W   = 3;
  localparam int MODE_W  = 3;
  localparam int PHYS_W  = LOG_W + PAGE_W;

  localparam logic [MODE_W-1:0] MODE_DIRECT   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_INDIRECT = 3'd1;
  localparam logic [MODE_W-1:0] MODE_INDEXED  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_IDX_IND  = 3'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic latchDirect;   // register final address from the live logical address
    logic latchPtrAddr;  // register pointer-fetch address and page
    logic latchPointer;  // register final address from the returned pointer
  } eauStrobes_t;

  function automatic logic isIndirect(input logic [MODE_W-1:0] m);
    return (m == MODE_INDIRECT) || (m == MODE_IDX_IND);
  endfunction

  function automatic logic isIndexed(input logic [MODE_W-1:0] m);
    return (m == MODE_INDEXED) || (m == MODE_IDX_IND);
  endfunction
endpackage

// File: rtl/eau_ctrl.sv
module eau_ctrl
  import eau_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              memValid,
  output eauStrobes_t       strobes,
  output logic              busy,
  output logic              addrValid
);
  typedef enum logic {ST_IDLE, ST_WAIT} eauState_t;
  eauState_t state, nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (isIndirect(mode)) begin
            strobes.latchPtrAddr = 1'b1;
            nextState            = ST_WAIT;
          end else begin
            strobes.latchDirect = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (memValid) begin
          strobes.latchPointer = 1'b1;
          nextState            = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addrValid <= 1'b0;
    end else begin
      state     <= nextState;
      addrValid <= strobes.latchDirect | strobes.latchPointer;
    end
  end

  assign busy = (state == ST_WAIT);

  AST_DIRECT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !isIndirect(mode) |=> addrValid && !busy); // R1
  AST_INDIRECT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && isIndirect(mode) |=> busy && !addrValid); // R8
  AST_RETURN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && memValid |=> addrValid && !busy); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !memValid |=> busy && !addrValid); // R10
endmodule

// File: rtl/eau_datapath.sv
module eau_datapath
  import eau_pkg::*;
#(
  parameter bit ZERO_IDX0 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eauStrobes_t       strobes,
  input  logic [MODE_W-1:0] mode,
  input  logic [LOG_W-1:0]  addrField,
  input  logic [SEL_W-1:0]  idxNum,
  input  logic [LOG_W-1:0]  idxLow,
  input  logic [PAGE_W-1:0] pageNum,
  input  logic [LOG_W-1:0]  memPtr,
  output logic [PHYS_W-1:0] memAddr,
  output logic [PHYS_W-1:0] physAddr
);
  logic [LOG_W-1:0]  idxUsed;
  logic [LOG_W-1:0]  linAddr;
  logic [PAGE_W-1:0] pageReg;
  logic              idxLive;

  generate
    if (ZERO_IDX0) begin : g_zeroIdx
      assign idxLive = isIndexed(mode) && (idxNum != '0);
    end else begin : g_plainIdx
      assign idxLive = isIndexed(mode) && (idxNum == idxNum);
    end
  endgenerate

  assign idxUsed = idxLive ? idxLow : '0;
  assign linAddr = addrField + idxUsed; // wraps modulo 2^LOG_W

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pageReg  <= '0;
      memAddr  <= '0;
      physAddr <= '0;
    end else begin
      if (strobes.latchDirect)
        physAddr <= {pageNum, linAddr};
      if (strobes.latchPtrAddr) begin
        pageReg <= pageNum;
        memAddr <= {pageNum, linAddr};
      end
      if (strobes.latchPointer)
        physAddr <= {pageReg, memPtr};
    end
  end

  AST_PTR_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.latchPointer |=> physAddr[PHYS_W-1:LOG_W] == memAddr[PHYS_W-1:LOG_W]); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(strobes) <= 1); // R10
endmodule

// File: rtl/eau_addr_gen.sv
module eau_addr_gen
  import eau_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [LOG_W-1:0]  addrField,
  input  logic [SEL_W-1:0]  idxNum,
  input  logic [LOG_W-1:0]  idxLow,
  input  logic [PAGE_W-1:0] pageNum,
  output logic              busy,
  output logic              addrValid,
  output logic [PHYS_W-1:0] physAddr,
  output logic              memReq,
  output logic [PHYS_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [LOG_W-1:0]  memPtr
);
  eauStrobes_t strobes;

  eau_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .memValid  (memValid),
    .strobes   (strobes),
    .busy      (busy),
    .addrValid (addrValid)
  );

  eau_datapath #(.ZERO_IDX0(1'b1)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .mode      (mode),
    .addrField (addrField),
    .idxNum    (idxNum),
    .idxLow    (idxLow),
    .pageNum   (pageNum),
    .memPtr    (memPtr),
    .memAddr   (memAddr),
    .physAddr  (physAddr)
  );

  assign memReq = busy;

  AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memValid |=> memReq && $stable(memAddr)); // R8
  AST_RESULT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && memValid |=> physAddr[PHYS_W-1:LOG_W] == $past(memAddr[PHYS_W-1:LOG_W])); // R7
endmodule

// File: tb/eau_addr_gen_bench.sv
`timescale 1ns/1ps
module eau_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [19:0] addrField = '0;
  logic [2:0]  idxNum = '0;
  logic [19:0] idxLow = '0;
  logic [5:0]  pageNum = '0;
  logic        busy, addrValid, memReq;
  logic [25:0] physAddr, memAddr;
  logic        memValid = 1'b0;
  logic [19:0] memPtr = '0;
  int          total = 0;
  int          bad = 0;
  int          memCnt = 0;

  always #4 clk = ~clk;

  eau_addr_gen u_eau_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addrField(addrField),
    .idxNum(idxNum), .idxLow(idxLow), .pageNum(pageNum), .busy(busy),
    .addrValid(addrValid), .physAddr(physAddr), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memPtr(memPtr)
  );

  function automatic logic [31:0] memWord(input logic [25:0] a);
    return ({6'd0, a} * 32'd2654435761) ^ 32'h5A5A_3C3C;
  endfunction

  // behavioural memory: answers two negedges after the request is seen
  always @(negedge clk) begin
    if (memReq && !memValid) begin
      if (memCnt == 1) begin
        memValid = 1'b1;
        memPtr   = memWord(memAddr)[19:0];
        memCnt   = 0;
      end else memCnt = memCnt + 1;
    end else memValid = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  vMode;
    logic [19:0] vField;
    logic [2:0]  vIdx;
    logic [19:0] vIdxLow;
    logic [5:0]  vPage;
    logic [15:0] vTag;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 20'h12345, 3'd3, 20'h003E7, 6'h2A, "R1"}, // direct ignores index
    '{3'd0, 20'hFFFFF, 3'd1, 20'h00001, 6'h00, "R7"}, // page 0
    '{3'd0, 20'h00000, 3'd1, 20'h00001, 6'h3F, "R7"}, // page 63
    '{3'd2, 20'h00100, 3'd5, 20'h00023, 6'h11, "R2"}, // indexed
    '{3'd2, 20'hFFFF0, 3'd1, 20'h00020, 6'h02, "R2"}, // indexed wrap
    '{3'd2, 20'h00500, 3'd0, 20'h12345, 6'h03, "R3"}, // register 0 is zero
    '{3'd1, 20'h00040, 3'd6, 20'h00100, 6'h05, "R4"}, // indirect
    '{3'd3, 20'h00200, 3'd7, 20'h00010, 6'h09, "R5"}, // pre-indexed indirect
    '{3'd3, 20'h00000, 3'd2, 20'h80077, 6'h21, "R6"}, // register indirect
    '{3'd3, 20'h00777, 3'd0, 20'hABCDE, 6'h07, "R3"}, // idx 0 in indirect
    '{3'd5, 20'h00300, 3'd4, 20'h00010, 6'h0C, "R9"}, // unused code
    '{3'd7, 20'h0FFFF, 3'd6, 20'h00001, 6'h30, "R9"}  // unused code
  };

  task automatic expect_addr(input vec_t v, output logic [25:0] fin,
                             output logic [25:0] ptrA, output bit ind);
    logic [19:0] off, lin;
    bit idxd;
    idxd = (v.vMode == 3'd2) || (v.vMode == 3'd3);
    ind  = (v.vMode == 3'd1) || (v.vMode == 3'd3);
    off  = (idxd && v.vIdx != 3'd0) ? v.vIdxLow : 20'd0;
    lin  = v.vField + off;
    ptrA = {v.vPage, lin};
    fin  = ind ? {v.vPage, memWord(ptrA)[19:0]} : {v.vPage, lin};
  endtask

  task automatic drive(input vec_t v);
    mode = v.vMode; addrField = v.vField; idxNum = v.vIdx;
    idxLow = v.vIdxLow; pageNum = v.vPage;
  endtask

  task automatic runVec(input vec_t v, input bit pokeBusy);
    logic [25:0] fin, ptrA, reqA;
    bit ind, sawReq;
    int cyc, valids;
    string tg;
    tg = string'(v.vTag);
    expect_addr(v, fin, ptrA, ind);
    @(negedge clk); drive(v); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (pokeBusy) begin   // R10: second start while busy
      chk(busy === 1'b1, "R8", "busy after start", 32'(busy), 32'd1);
      start = 1'b1; mode = 3'd0; addrField = 20'h55555; pageNum = 6'h01;
    end
    cyc = 1; sawReq = 0; valids = 0; reqA = '0;
    while (!addrValid && cyc < 20) begin
      if (memReq) begin sawReq = 1; reqA = memAddr; end
      @(negedge clk); start = 1'b0; cyc++;
    end
    chk(physAddr === fin, tg, "physAddr", 32'(physAddr), 32'(fin));
    chk(sawReq == ind, tg, "memReq seen", 32'(sawReq), 32'(ind));
    chk(cyc == (ind ? 3 : 1), ind ? "R8" : "R1", "latency", 32'(cyc), ind ? 32'd3 : 32'd1);
    if (ind) chk(reqA === ptrA, tg, "pointer addr", 32'(reqA), 32'(ptrA));
    @(negedge clk);
    if (addrValid) valids++;
    @(negedge clk);
    if (addrValid) valids++;
    chk(valids == 0, pokeBusy ? "R10" : "R8", "extra addrValid", 32'(valids), 32'd0);
    chk(busy === 1'b0, "R8", "busy after done", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R8 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy === 1'b0, "R11", "busy in reset", 32'(busy), 32'd0);
    chk(memReq === 1'b0, "R11", "memReq in reset", 32'(memReq), 32'd0);
    chk(addrValid === 1'b0, "R11", "addrValid in reset", 32'(addrValid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addrValid === 1'b0, "R11", "addrValid idle", 32'(addrValid), 32'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], 1'b0);

    // R10: start ignored while a pointer fetch is pending (indirect, page 0x14)
    runVec('{3'd1, 20'h0ABCD, 3'd0, 20'h00000, 6'h14, "R10"}, 1'b1);
    // R10 with indexed-indirect
    runVec('{3'd3, 20'h00010, 3'd4, 20'hFFFF8, 6'h3F, "R10"}, 1'b1);
    // back-to-back direct after indirect, R1
    runVec('{3'd0, 20'h00001, 3'd0, 20'h00000, 6'h01, "R1"}, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule